// File: doc/BRIEF.md
# NAND Flash Bus Cycle Engine

This block produces one bus cycle at a time on an 8-bit parallel NAND flash interface of the older removable-card kind. A controller above it hands over a request that names a cycle kind and one byte. The kinds are command latch, address latch, data write and data read. The engine then steps the four control strobes through a fixed pattern, drives the data bus or releases it, and reports completion with a one-cycle done pulse. For a read, the done pulse carries the sampled byte. Choosing opcodes and addresses, and buffering pages, belong to the controller.

The request side is valid/ready. `req_ready` is high only while the engine is idle, so a request is taken on the first edge where both `req_valid` and `req_ready` are high. `req_ready` then stays low until the done pulse. The kind, byte, flags and step length are all sampled on that accepting edge. A `req_valid` raised while the engine is busy is neither accepted nor remembered.

The response side has no back-pressure. `rsp_valid` is high for exactly one cycle. `rsp_byte` keeps its value until the next read completes, so a consumer that is late may still read it.

Every strobe step lasts `step_len` clocks, which lets the caller meet the flash setup and hold times. The flash ready/busy line is brought in through a two-flop synchronizer and is exposed to the controller.

Top module: `nand_cycle_engine`

## Requirements
- R1: After reset, and while the engine is idle before any request, the strobes read {nre,ale,nwe,cle} = 4'b1010, `bus_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A command request (req_kind = 2'b00) drives `req_byte` on `bus_out` with `bus_oe` = 1. It steps the strobes through 1010, 1011, 1001, 1011, 1010.
- R3: An address request (req_kind = 2'b01) drives `req_byte` with `bus_oe` = 1. It steps through 1100 then 1110. With `req_first` = 1, an extra 1110 step comes before these. With `req_last` = 1, an extra 1010 step comes after them. Without `req_last`, the strobes stay at 1110 after the done pulse.
- R4: A write request (req_kind = 2'b10) drives `req_byte` with `bus_oe` = 1. It steps through 1000 then 1010. nwe is never low unless `bus_oe` is 1.
- R5: A read request (req_kind = 2'b11) keeps `bus_oe` = 0 and steps through 0010 then 1010. `rsp_byte` equals `bus_in` as it stood on the last clock of the 0010 step.
- R6: Each step lasts `step_len` clocks, and a value of 0 counts as 1. `rsp_valid` rises on the clock after the last step ends. A request of n steps therefore occupies n*step_len clocks between the accepting edge and the done pulse.
- R7: `req_ready` is low from the accepting edge until the done pulse and is high during the done pulse. A request raised while busy has no effect. `rsp_valid` is high for a single clock.
- R8: `rb_sync` follows `rb_raw` through exactly two register stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request will be taken |
| req_kind | input | 2 | 00 command, 01 address, 10 write, 11 read |
| req_byte | input | DW | Opcode, address byte or write data |
| req_first | input | 1 | Address only: open the address phase |
| req_last | input | 1 | Address only: close the address phase |
| step_len | input | LEN_W | Clocks per strobe step (0 treated as 1) |
| rsp_valid | output | 1 | One-clock done pulse |
| rsp_byte | output | DW | Byte read by the last read request |
| nre | output | 1 | Read enable, active low |
| ale | output | 1 | Address latch enable |
| nwe | output | 1 | Write enable, active low |
| cle | output | 1 | Command latch enable |
| bus_out | output | DW | Data bus value when driving |
| bus_oe | output | 1 | Data bus output enable |
| bus_in | input | DW | Data bus value from the flash |
| rb_raw | input | 1 | Asynchronous ready/busy from the flash |
| rb_sync | output | 1 | Synchronized ready/busy |

## Verification
Three behaviours need care: the point at which a read is sampled, the step counting, and requests that arrive while the engine is busy.

- **Read sampling.** The bench puts the wanted byte on `bus_in` only during the last clock of the nRE-low step and drives its complement at all other times. An engine that samples one clock early or one clock late returns the complement.
- **Step counting.** Step lengths of 0, 1, 2, 3 and 4 are exercised. An off-by-one counter, or a zero length that wraps round to the counter maximum, shows up as a wrong total duration.
- **Busy requests and address phases.** A read request offered in the middle of a write must leave the write pattern and the bus direction untouched, and must not start afterwards. A multi-byte address phase must hold ALE high between bytes; an engine that falls back to idle there would drop the address latch.

// File: rtl/nce_pkg.sv
package nce_pkg;
  typedef enum logic [1:0] {
    K_CMD   = 2'b00,
    K_ADDR  = 2'b01,
    K_WRITE = 2'b10,
    K_READ  = 2'b11
  } kind_e;

  // strobe nibble order: {nre, ale, nwe, cle}
  localparam logic [3:0] NIB_IDLE   = 4'b1010;
  localparam logic [3:0] NIB_CLE    = 4'b1011;
  localparam logic [3:0] NIB_CLE_WE = 4'b1001;
  localparam logic [3:0] NIB_ALE    = 4'b1110;
  localparam logic [3:0] NIB_ALE_WE = 4'b1100;
  localparam logic [3:0] NIB_WE     = 4'b1000;
  localparam logic [3:0] NIB_RE     = 4'b0010;

  localparam int MAX_STEPS = 5;
  localparam int IDX_W     = $clog2(MAX_STEPS + 1);
endpackage

// File: rtl/nce_sync.sv
module nce_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/nce_step_timer.sv
module nce_step_timer #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  output logic             expired
);
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] eff_len;

  assign eff_len = (len == '0) ? LEN_W'(1) : len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= eff_len - LEN_W'(1);
    else if (cnt != '0)    cnt <= cnt - LEN_W'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/nce_pattern.sv
module nce_pattern
  import nce_pkg::*;
(
  input  kind_e                 kind,
  input  logic                  first,
  input  logic                  last,
  output logic [3:0]            seq [MAX_STEPS],
  output logic [IDX_W-1:0]      nsteps
);
  always_comb begin
    for (int i = 0; i < MAX_STEPS; i++) seq[i] = NIB_IDLE;
    nsteps = IDX_W'(1);
    unique case (kind)
      K_CMD: begin
        seq[0] = NIB_IDLE;  seq[1] = NIB_CLE;  seq[2] = NIB_CLE_WE;
        seq[3] = NIB_CLE;   seq[4] = NIB_IDLE;
        nsteps = IDX_W'(5);
      end
      K_ADDR: begin
        unique case ({first, last})
          2'b00: begin
            seq[0] = NIB_ALE_WE; seq[1] = NIB_ALE;
            nsteps = IDX_W'(2);
          end
          2'b01: begin
            seq[0] = NIB_ALE_WE; seq[1] = NIB_ALE; seq[2] = NIB_IDLE;
            nsteps = IDX_W'(3);
          end
          2'b10: begin
            seq[0] = NIB_ALE; seq[1] = NIB_ALE_WE; seq[2] = NIB_ALE;
            nsteps = IDX_W'(3);
          end
          default: begin
            seq[0] = NIB_ALE; seq[1] = NIB_ALE_WE; seq[2] = NIB_ALE;
            seq[3] = NIB_IDLE;
            nsteps = IDX_W'(4);
          end
        endcase
      end
      K_WRITE: begin
        seq[0] = NIB_WE; seq[1] = NIB_IDLE;
        nsteps = IDX_W'(2);
      end
      default: begin
        seq[0] = NIB_RE; seq[1] = NIB_IDLE;
        nsteps = IDX_W'(2);
      end
    endcase
  end
endmodule

// File: rtl/nand_cycle_engine.sv
module nand_cycle_engine
  import nce_pkg::*;
#(
  parameter int DW    = 8,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic [DW-1:0]    req_byte,
  input  logic             req_first,
  input  logic             req_last,
  input  logic [LEN_W-1:0] step_len,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_byte,
  output logic             nre,
  output logic             ale,
  output logic             nwe,
  output logic             cle,
  output logic [DW-1:0]    bus_out,
  output logic             bus_oe,
  input  logic [DW-1:0]    bus_in,
  input  logic             rb_raw,
  output logic             rb_sync
);
  logic             busy;
  kind_e            kind_q;
  logic             first_q, last_q;
  logic [LEN_W-1:0] len_q;
  logic [IDX_W-1:0] idx;
  logic [3:0]       nib_q;

  kind_e            pat_kind;
  logic             pat_first, pat_last;
  logic [LEN_W-1:0] len_sel;
  logic [3:0]       seq [MAX_STEPS];
  logic [IDX_W-1:0] nsteps;
  logic [IDX_W-1:0] idx_nx;

  logic accept, expired, on_last, advance, finish;

  assign accept    = req_valid && !busy;
  assign req_ready = !busy;

  // while idle the pattern looks at the live request, while busy at the latched one
  assign pat_kind  = busy ? kind_q  : kind_e'(req_kind);
  assign pat_first = busy ? first_q : req_first;
  assign pat_last  = busy ? last_q  : req_last;
  assign len_sel   = busy ? len_q   : step_len;

  nce_pattern u_pat (
    .kind   (pat_kind),
    .first  (pat_first),
    .last   (pat_last),
    .seq    (seq),
    .nsteps (nsteps)
  );

  assign idx_nx  = idx + IDX_W'(1);
  assign on_last = (idx_nx == nsteps);
  assign advance = busy && expired && !on_last;
  assign finish  = busy && expired && on_last;

  nce_step_timer #(.LEN_W(LEN_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept || advance),
    .len     (len_sel),
    .expired (expired)
  );

  nce_sync #(.STAGES(2)) u_rb (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rb_raw),
    .q     (rb_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      kind_q    <= K_CMD;
      first_q   <= 1'b0;
      last_q    <= 1'b0;
      len_q     <= '0;
      idx       <= '0;
      nib_q     <= NIB_IDLE;
      bus_oe    <= 1'b0;
      bus_out   <= '0;
      rsp_valid <= 1'b0;
      rsp_byte  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        kind_q  <= kind_e'(req_kind);
        first_q <= req_first;
        last_q  <= req_last;
        len_q   <= step_len;
        idx     <= '0;
        nib_q   <= seq[0];
        bus_oe  <= (kind_e'(req_kind) != K_READ);
        bus_out <= req_byte;
      end else if (busy) begin
        if (kind_q == K_READ && idx == '0 && expired)
          rsp_byte <= bus_in;
        if (finish) begin
          busy      <= 1'b0;
          rsp_valid <= 1'b1;
        end else if (advance) begin
          idx   <= idx_nx;
          nib_q <= seq[idx_nx];
        end
      end
    end
  end

  assign {nre, ale, nwe, cle} = nib_q;
endmodule

// File: rtl/nce_checker.sv
module nce_checker (
  input logic clk,
  input logic rst_n,
  input logic nre,
  input logic ale,
  input logic nwe,
  input logic cle,
  input logic bus_oe,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input logic rb_raw,
  input logic rb_sync
);
  logic [1:0] warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  a_r5_bus_released_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    !nre |-> !bus_oe);

  a_r4_write_strobe_drives: assert property (@(posedge clk) disable iff (!rst_n)
    !nwe |-> bus_oe);

  a_r3_latches_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r7_accept_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r7_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

  a_r8_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd2) |-> (rb_sync == $past(rb_raw, 2)));
endmodule

bind nand_cycle_engine nce_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .nre       (nre),
  .ale       (ale),
  .nwe       (nwe),
  .cle       (cle),
  .bus_oe    (bus_oe),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rb_raw    (rb_raw),
  .rb_sync   (rb_sync)
);

// File: tb/nand_cycle_engine_test.sv
module nand_cycle_engine_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_kind = 2'b00;
  logic [7:0] req_byte = 8'h00;
  logic       req_first = 1'b0;
  logic       req_last = 1'b0;
  logic [3:0] step_len = 4'd1;
  logic       rsp_valid;
  logic [7:0] rsp_byte;
  logic       nre, ale, nwe, cle;
  logic [7:0] bus_out;
  logic       bus_oe;
  logic [7:0] bus_in = 8'h00;
  logic       rb_raw = 1'b0;
  logic       rb_sync;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  nand_cycle_engine uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_byte(req_byte), .req_first(req_first),
    .req_last(req_last), .step_len(step_len), .rsp_valid(rsp_valid),
    .rsp_byte(rsp_byte), .nre(nre), .ale(ale), .nwe(nwe), .cle(cle),
    .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in), .rb_raw(rb_raw),
    .rb_sync(rb_sync)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic        first;
    logic        last;
    logic [3:0]  len;
    logic [7:0]  byt;
    logic [7:0]  rd;
    logic [2:0]  n;
    logic [19:0] seq;
  } vec_t;

  // strobe steps packed first-step-high, nibble = {nre, ale, nwe, cle}
  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 1'b0, 4'd1, 8'h00, 8'h00, 3'd5, 20'hAB9BA},
    '{2'd0, 1'b0, 1'b0, 4'd3, 8'h80, 8'h00, 3'd5, 20'hAB9BA},
    '{2'd1, 1'b1, 1'b0, 4'd2, 8'h12, 8'h00, 3'd3, 20'hECE00},
    '{2'd1, 1'b0, 1'b0, 4'd1, 8'h34, 8'h00, 3'd2, 20'hCE000},
    '{2'd1, 1'b0, 1'b1, 4'd2, 8'h56, 8'h00, 3'd3, 20'hCEA00},
    '{2'd2, 1'b0, 1'b0, 4'd0, 8'hA5, 8'h00, 3'd2, 20'h8A000},
    '{2'd2, 1'b0, 1'b0, 4'd4, 8'h3C, 8'h00, 3'd2, 20'h8A000},
    '{2'd3, 1'b0, 1'b0, 4'd2, 8'h00, 8'h5A, 3'd2, 20'h2A000},
    '{2'd1, 1'b1, 1'b1, 4'd1, 8'h7F, 8'h00, 3'd4, 20'hECEA0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string tag(input logic [1:0] k);
    case (k)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic run(input vec_t v, input bit poke);
    logic [3:0] tr [64];
    int le, t, oe_bad, bus_bad, rdy_bad;
    logic [3:0] e;
    le = (v.len == 4'd0) ? 1 : int'(v.len);
    @(negedge clk);
    req_valid = 1'b1; req_kind = v.kind; req_byte = v.byt;
    req_first = v.first; req_last = v.last; step_len = v.len;
    bus_in = (v.kind == 2'd3) ? ~v.rd : 8'h00;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    t = 0; oe_bad = 0; bus_bad = 0; rdy_bad = 0;
    while (t < 64 && !rsp_valid) begin
      if (v.kind == 2'd3) bus_in = (t == le - 1) ? v.rd : ~v.rd;
      if (poke && t == 1) begin req_valid = 1'b1; req_kind = 2'd3; end
      if (poke && t == 2) req_valid = 1'b0;
      tr[t] = {nre, ale, nwe, cle};
      if (bus_oe != (v.kind != 2'd3)) oe_bad++;
      if (v.kind != 2'd3 && bus_out != v.byt) bus_bad++;
      if (req_ready) rdy_bad++;
      t++;
      @(negedge clk);
    end
    check(t == int'(v.n) * le, "R6 duration", t, int'(v.n) * le);
    for (int k = 0; k < int'(v.n); k++) begin
      e = v.seq[19 - 4*k -: 4];
      if (k * le + le - 1 < 64) begin
        check(tr[k*le] == e, tag(v.kind), int'(tr[k*le]), int'(e));
        check(tr[k*le + le - 1] == e, tag(v.kind), int'(tr[k*le + le - 1]), int'(e));
      end
    end
    check(oe_bad == 0, tag(v.kind), oe_bad, 0);
    check(bus_bad == 0, tag(v.kind), bus_bad, 0);
    check(rdy_bad == 0, "R7 ready low while busy", rdy_bad, 0);
    check(rsp_valid && req_ready, "R7 done pulse with ready", int'({rsp_valid, req_ready}), 3);
    e = v.seq[19 - 4*(int'(v.n) - 1) -: 4];
    check({nre, ale, nwe, cle} == e, tag(v.kind), int'({nre, ale, nwe, cle}), int'(e));
    if (v.kind == 2'd3) check(rsp_byte == v.rd, "R5 read sample", int'(rsp_byte), int'(v.rd));
    @(negedge clk);
    check(!rsp_valid, "R7 single pulse", int'(rsp_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual expired expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({nre, ale, nwe, cle} == 4'b1010, "R1 idle strobes", int'({nre, ale, nwe, cle}), 'hA);
    check(!bus_oe && req_ready && !rsp_valid, "R1 idle flags",
          int'({bus_oe, req_ready, rsp_valid}), 2);

    for (int i = 0; i < NV; i++) run(VEC[i], 1'b0);

    // R7: read offered during a write is ignored
    run(VEC[6], 1'b1);
    repeat (4) begin
      check(!rsp_valid && bus_oe && {nre, ale, nwe, cle} == 4'b1010,
            "R7 busy request ignored", int'({rsp_valid, bus_oe, nre, ale, nwe, cle}), 'h1A);
      @(negedge clk);
    end

    // R8: two-stage synchronizer
    rb_raw = 1'b1;
    @(posedge clk); @(negedge clk);
    check(rb_sync == 1'b0, "R8 one stage", int'(rb_sync), 0);
    @(posedge clk); @(negedge clk);
    check(rb_sync == 1'b1, "R8 two stages", int'(rb_sync), 1);
    rb_raw = 1'b0;
    @(posedge clk); @(negedge clk);
    check(rb_sync == 1'b1, "R8 fall one stage", int'(rb_sync), 1);
    @(posedge clk); @(negedge clk);
    check(rb_sync == 1'b0, "R8 fall two stages", int'(rb_sync), 0);

    // R1: reset in mid-command returns to idle
    req_valid = 1'b1; req_kind = 2'd0; req_byte = 8'h70; step_len = 4'd3;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check({nre, ale, nwe, cle} == 4'b1010 && !bus_oe && req_ready && !rsp_valid,
          "R1 reset mid-cycle", int'({nre, ale, nwe, cle, bus_oe, req_ready, rsp_valid}), 'h52);
    rst_n = 1'b1;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule